// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This unit is the execute stage of a small 8-bit accumulator machine with 13-bit instruction words. Each cycle it may accept one instruction word, along with the accumulator value, the byte read from the addressed register, the bank selection and the current Z, C and DC status bits. It decodes the register-operand instruction group and computes the 8-bit result. It then says whether that result goes to the accumulator or back to the register. Alongside the result it gives the new status bits and a per-bit update enable for each, a skip request for the decrement-and-skip forms, and the full banked register address.

Every output is registered, so an instruction presented in one cycle shows its effect one clock edge later. Words outside the decoded set produce no write, no skip and no flag update. The surrounding core uses the write strobes, the flag enables and the skip request to commit state and to steer its program counter.

Top module: `acc_alu_exec`

## Requirements
- R1: Outputs are registered with one cycle of latency: `out_valid` follows `in_valid` one edge later. While reset is low, every output is 0. A cycle with `out_valid` low carries no write and no skip.
- R2: The operand word has bit 12 = 0, the operation in bits 11:7 and the destination in bit 6 (0 = accumulator, 1 = register). At most one of `wr_acc` and `wr_reg` is high.
- R3: Operation code 00111 is an add (accumulator + register). Operation code 00010 is a subtract (register − accumulator). Both update Z, C and DC. C is the carry out of bit 7 on an add and is 1 on a subtract when no borrow occurs. DC is the same quantity taken at bit 3.
- R4: Code 01010 adds one to the register and code 00011 subtracts one from it. Both update only Z.
- R5: Code 01011 decrements the register and raises `skip` when the result is zero. It changes no flags.
- R6: Codes 00100 (OR), 00101 (AND), 00110 (XOR), 01001 (complement of the register) and 01000 (move register) update only Z. Code 00000 with bit 6 = 1 writes the accumulator to the register and changes no flag.
- R7: Code 00001 with bit 6 = 1 clears the register and sets Z. The word 0x080 clears the accumulator and sets Z.
- R8: Code 01100 rotates the register right through carry: register bit 0 becomes C and the old C becomes result bit 7. Only C is updated.
- R9: `reg_addr` is the bank input concatenated above instruction bits 5:0.
- R10: Any other word, including words with bit 12 = 1, code 00000 with bit 6 = 0, and code 00001 with bit 6 = 0 and a nonzero register field, gives no write, no skip and no flag enable.
- R11: When its enable is high, Z is 1 exactly when the result is zero. A flag whose enable is low outputs its input value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 13 | Instruction word |
| acc | input | 8 | Accumulator value |
| reg_rd | input | 8 | Data of the addressed register |
| bank | input | BANK_W | Bank selection |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit carry flag |
| out_valid | output | 1 | Result valid |
| result | output | 8 | Computed value |
| wr_acc | output | 1 | Write result to accumulator |
| wr_reg | output | 1 | Write result to register |
| reg_addr | output | BANK_W+6 | Banked register address |
| z_out | output | 1 | Zero flag after the instruction |
| c_out | output | 1 | Carry flag after the instruction |
| dc_out | output | 1 | Digit carry flag after the instruction |
| z_en | output | 1 | Zero flag updated |
| c_en | output | 1 | Carry flag updated |
| dc_en | output | 1 | Digit carry updated |
| skip | output | 1 | Skip next instruction |

## Verification
The bench builds the unit with the default two-bit bank, so register addresses in every bank, up to the top address 0xFF, can be reached. The stimulus covers the nibble carry and byte carry corners of the add and the subtract. It also covers wrap-around on increment, a zero result from decrement-and-skip, and rotation with carry set. Undecoded words that sit next to decoded ones are included, and an idle cycle is driven between instructions.

// File: rtl/acc_alu_exec.sv
module acc_alu_exec #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [12:0]       instr,
  input  logic [7:0]        acc,
  input  logic [7:0]        reg_rd,
  input  logic [BANK_W-1:0] bank,
  input  logic              z_in,
  input  logic              c_in,
  input  logic              dc_in,
  output logic              out_valid,
  output logic [7:0]        result,
  output logic              wr_acc,
  output logic              wr_reg,
  output logic [BANK_W+5:0] reg_addr,
  output logic              z_out,
  output logic              c_out,
  output logic              dc_out,
  output logic              z_en,
  output logic              c_en,
  output logic              dc_en,
  output logic              skip
);
  localparam int AW = BANK_W + 6;

  wire [4:0] op      = instr[11:7];
  wire       to_reg  = instr[6];
  wire       grp     = ~instr[12];

  wire [8:0] add9 = {1'b0, acc} + {1'b0, reg_rd};
  wire [4:0] addn = {1'b0, acc[3:0]} + {1'b0, reg_rd[3:0]};
  wire [8:0] sub9 = {1'b0, reg_rd} + {1'b0, ~acc} + 9'd1;
  wire [4:0] subn = {1'b0, reg_rd[3:0]} + {1'b0, ~acc[3:0]} + 5'd1;

  logic [7:0] res;
  logic       hit, fz, fc, fdc, nc, ndc, sk;

  always_comb begin
    res = '0; hit = 1'b0; fz = 1'b0; fc = 1'b0; fdc = 1'b0;
    nc = c_in; ndc = dc_in; sk = 1'b0;
    if (grp) begin
      case (op)
        5'h00: if (to_reg) begin hit = 1'b1; res = acc; end
        5'h01: if (to_reg || instr[5:0] == 6'd0) begin hit = 1'b1; fz = 1'b1; end
        5'h02: begin hit = 1'b1; res = sub9[7:0]; fz = 1'b1; fc = 1'b1; fdc = 1'b1;
                     nc = sub9[8]; ndc = subn[4]; end
        5'h03: begin hit = 1'b1; res = reg_rd - 8'd1; fz = 1'b1; end
        5'h04: begin hit = 1'b1; res = acc | reg_rd; fz = 1'b1; end
        5'h05: begin hit = 1'b1; res = acc & reg_rd; fz = 1'b1; end
        5'h06: begin hit = 1'b1; res = acc ^ reg_rd; fz = 1'b1; end
        5'h07: begin hit = 1'b1; res = add9[7:0]; fz = 1'b1; fc = 1'b1; fdc = 1'b1;
                     nc = add9[8]; ndc = addn[4]; end
        5'h08: begin hit = 1'b1; res = reg_rd; fz = 1'b1; end
        5'h09: begin hit = 1'b1; res = ~reg_rd; fz = 1'b1; end
        5'h0A: begin hit = 1'b1; res = reg_rd + 8'd1; fz = 1'b1; end
        5'h0B: begin hit = 1'b1; res = reg_rd - 8'd1; sk = (reg_rd == 8'd1); end
        5'h0C: begin hit = 1'b1; res = {c_in, reg_rd[7:1]}; fc = 1'b1; nc = reg_rd[0]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0; wr_acc <= 1'b0; wr_reg <= 1'b0;
      reg_addr <= '0; z_out <= 1'b0; c_out <= 1'b0; dc_out <= 1'b0;
      z_en <= 1'b0; c_en <= 1'b0; dc_en <= 1'b0; skip <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= res;
      wr_acc    <= in_valid & hit & ~to_reg;
      wr_reg    <= in_valid & hit & to_reg;
      reg_addr  <= AW'({bank, instr[5:0]});
      z_en      <= in_valid & fz;
      c_en      <= in_valid & fc;
      dc_en     <= in_valid & fdc;
      skip      <= in_valid & sk;
      z_out     <= fz ? (res == 8'd0) : z_in;
      c_out     <= nc;
      dc_out    <= ndc;
    end
  end
endmodule

module acc_alu_exec_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [12:0]       instr,
  input logic [BANK_W-1:0] bank,
  input logic              c_in,
  input logic              out_valid,
  input logic [7:0]        result,
  input logic              wr_acc,
  input logic              wr_reg,
  input logic [BANK_W+5:0] reg_addr,
  input logic              z_out,
  input logic              c_out,
  input logic              z_en,
  input logic              c_en,
  input logic              dc_en,
  input logic              skip
);
  a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && wr_reg));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_acc && !wr_reg && !skip));
  a_r5_skip_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (!z_en && !c_en && !dc_en && result == 8'd0));
  a_r11_z_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && z_en) |-> (z_out == (result == 8'd0)));
  a_r11_c_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_en) |-> (c_out == $past(c_in)));
  a_r9_bank_addr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (reg_addr == $past({bank, instr[5:0]})));
endmodule

bind acc_alu_exec acc_alu_exec_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .bank(bank), .c_in(c_in),
  .out_valid(out_valid), .result(result), .wr_acc(wr_acc), .wr_reg(wr_reg),
  .reg_addr(reg_addr), .z_out(z_out), .c_out(c_out), .z_en(z_en),
  .c_en(c_en), .dc_en(dc_en), .skip(skip)
);

// File: tb/acc_alu_exec_tb.sv
`timescale 1ns/1ps
module acc_alu_exec_tb;
  localparam int BANK_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [12:0] instr = '0;
  logic [7:0] acc = '0, reg_rd = '0;
  logic [BANK_W-1:0] bank = '0;
  logic z_in = 1'b0, c_in = 1'b0, dc_in = 1'b0;
  logic out_valid, wr_acc, wr_reg, z_out, c_out, dc_out, z_en, c_en, dc_en, skip;
  logic [7:0] result;
  logic [BANK_W+5:0] reg_addr;

  always #2 clk = ~clk;

  acc_alu_exec #(.BANK_W(BANK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .acc(acc),
    .reg_rd(reg_rd), .bank(bank), .z_in(z_in), .c_in(c_in), .dc_in(dc_in),
    .out_valid(out_valid), .result(result), .wr_acc(wr_acc), .wr_reg(wr_reg),
    .reg_addr(reg_addr), .z_out(z_out), .c_out(c_out), .dc_out(dc_out),
    .z_en(z_en), .c_en(c_en), .dc_en(dc_en), .skip(skip)
  );

  typedef struct {
    logic v, wa, wr, sk, z, c, dc, ze, ce, dce;
    logic [7:0] res;
    logic [BANK_W+5:0] addr;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [12:0] enc(input logic [4:0] op, input logic d, input logic [5:0] r);
    return {1'b0, op, d, r};
  endfunction

  function automatic exp_t model(input logic v, input logic [12:0] i, input logic [7:0] a,
      input logic [7:0] r, input logic [BANK_W-1:0] b, input logic zi, input logic ci,
      input logic dci, input string tag);
    exp_t e;
    logic hit;
    logic [8:0] w;
    logic [4:0] n;
    hit = 1'b0;
    e.v = v; e.tag = tag; e.sk = 1'b0; e.res = 8'h00; e.ze = 1'b0; e.ce = 1'b0; e.dce = 1'b0;
    e.z = zi; e.c = ci; e.dc = dci; e.addr = {b, i[5:0]};
    if (!i[12]) begin
      case (i[11:7])
        5'h00: if (i[6]) begin hit = 1; e.res = a; end
        5'h01: if (i[6] || i[5:0] == 0) begin hit = 1; e.res = 0; e.ze = 1; end
        5'h02: begin hit = 1; w = 9'(r) - 9'(a); n = 5'(r[3:0]) - 5'(a[3:0]);
               e.res = w[7:0]; e.ze = 1; e.ce = 1; e.dce = 1;
               e.c = (r >= a); e.dc = (r[3:0] >= a[3:0]); end
        5'h03: begin hit = 1; e.res = r - 1; e.ze = 1; end
        5'h04: begin hit = 1; e.res = a | r; e.ze = 1; end
        5'h05: begin hit = 1; e.res = a & r; e.ze = 1; end
        5'h06: begin hit = 1; e.res = a ^ r; e.ze = 1; end
        5'h07: begin hit = 1; w = 9'(a) + 9'(r); n = 5'(a[3:0]) + 5'(r[3:0]);
               e.res = w[7:0]; e.ze = 1; e.ce = 1; e.dce = 1; e.c = w[8]; e.dc = n[4]; end
        5'h08: begin hit = 1; e.res = r; e.ze = 1; end
        5'h09: begin hit = 1; e.res = ~r; e.ze = 1; end
        5'h0A: begin hit = 1; e.res = r + 1; e.ze = 1; end
        5'h0B: begin hit = 1; e.res = r - 1; e.sk = (e.res == 0); end
        5'h0C: begin hit = 1; e.res = {ci, r[7:1]}; e.ce = 1; e.c = r[0]; end
        default: ;
      endcase
    end
    if (e.ze) e.z = (e.res == 0);
    e.wa = v & hit & ~i[6];
    e.wr = v & hit & i[6];
    e.sk = v & e.sk; e.ze = v & e.ze; e.ce = v & e.ce; e.dce = v & e.dce;
    return e;
  endfunction

  task automatic drive(input logic v, input logic [12:0] i, input logic [7:0] a,
      input logic [7:0] r, input logic [BANK_W-1:0] b, input logic zi, input logic ci,
      input logic dci, input string tag);
    @(negedge clk);
    in_valid = v; instr = i; acc = a; reg_rd = r; bank = b; z_in = zi; c_in = ci; dc_in = dci;
    q.push_back(model(v, i, a, r, b, zi, ci, dci, tag));
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [12:0] got, want;
      e = q.pop_front();
      got  = {out_valid, wr_acc, wr_reg, skip, z_en, c_en, dc_en, 6'd0};
      want = {e.v, e.wa, e.wr, e.sk, e.ze, e.ce, e.dce, 6'd0};
      if (e.v) begin
        got[5:3]  = {z_out, c_out, dc_out};
        want[5:3] = {e.z, e.c, e.dc};
      end
      checks++;
      if (got != want || (e.v && reg_addr != e.addr) || ((e.wa || e.wr) && result != e.res)) begin
        fails++;
        $display("FAIL %s: ctl/flags %b addr %h res %h, expected %b addr %h res %h",
                 e.tag, got, reg_addr, result, want, e.addr, e.res);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, wr_acc, wr_reg, skip, z_en, c_en, dc_en, result, reg_addr} != '0) begin
      fails++;
      $display("FAIL R1 reset: outputs %b, expected 0",
               {out_valid, wr_acc, wr_reg, skip, z_en, c_en, dc_en, result, reg_addr});
    end
    rst_n = 1'b1;
    drive(1, enc(5'h07, 0, 6'h05), 8'h0F, 8'h01, 2'd0, 0, 0, 0, "R3 add nibble carry");
    drive(1, enc(5'h07, 1, 6'h06), 8'hFF, 8'h01, 2'd1, 0, 0, 0, "R3 add byte carry zero");
    drive(1, enc(5'h02, 0, 6'h10), 8'h37, 8'h37, 2'd0, 0, 0, 0, "R3 sub equal");
    drive(1, enc(5'h02, 1, 6'h11), 8'h01, 8'h10, 2'd0, 1, 0, 1, "R3 sub nibble borrow");
    drive(1, enc(5'h02, 0, 6'h12), 8'h01, 8'h00, 2'd0, 1, 1, 1, "R3 sub borrow");
    drive(0, enc(5'h07, 0, 6'h00), 8'h01, 8'h01, 2'd0, 0, 0, 0, "R1 idle cycle");
    drive(1, enc(5'h0A, 1, 6'h20), 8'h00, 8'hFF, 2'd2, 0, 1, 1, "R4 inc wrap");
    drive(1, enc(5'h03, 0, 6'h21), 8'h00, 8'h01, 2'd2, 0, 1, 0, "R4 dec to zero");
    drive(1, enc(5'h0B, 1, 6'h22), 8'h00, 8'h01, 2'd0, 1, 1, 1, "R5 djz skip");
    drive(1, enc(5'h0B, 0, 6'h23), 8'h00, 8'h05, 2'd0, 0, 0, 0, "R5 djz no skip");
    drive(1, enc(5'h04, 0, 6'h01), 8'hA0, 8'h05, 2'd0, 1, 1, 0, "R6 or");
    drive(1, enc(5'h05, 1, 6'h02), 8'hF0, 8'h0F, 2'd0, 0, 0, 1, "R6 and zero");
    drive(1, enc(5'h06, 0, 6'h03), 8'h5A, 8'hFF, 2'd0, 0, 1, 0, "R6 xor");
    drive(1, enc(5'h09, 1, 6'h04), 8'h00, 8'hFF, 2'd0, 0, 0, 0, "R6 com");
    drive(1, enc(5'h08, 0, 6'h07), 8'h00, 8'h00, 2'd0, 0, 1, 1, "R6 mov reg to acc");
    drive(1, enc(5'h00, 1, 6'h08), 8'h00, 8'h44, 2'd0, 0, 1, 0, "R6 mov acc to reg");
    drive(1, 13'h0080, 8'h99, 8'h00, 2'd0, 0, 1, 1, "R7 clear acc");
    drive(1, enc(5'h01, 1, 6'h09), 8'h99, 8'h77, 2'd0, 0, 0, 0, "R7 clear reg");
    drive(1, enc(5'h0C, 1, 6'h0A), 8'h00, 8'h01, 2'd0, 0, 1, 0, "R8 rrc carry in");
    drive(1, enc(5'h0C, 0, 6'h0B), 8'h00, 8'h80, 2'd0, 1, 0, 1, "R8 rrc zero carry");
    drive(1, enc(5'h08, 1, 6'h3F), 8'h00, 8'h12, 2'd3, 0, 0, 0, "R9 top address");
    drive(1, 13'h0081, 8'h00, 8'h00, 2'd0, 0, 1, 1, "R10 near clear acc");
    drive(1, 13'h0005, 8'h00, 8'h00, 2'd0, 1, 0, 1, "R10 code 0 acc dest");
    drive(1, enc(5'h0D, 1, 6'h01), 8'h00, 8'h01, 2'd0, 0, 1, 0, "R10 code 0D");
    drive(1, 13'h1380, 8'h01, 8'h01, 2'd0, 1, 1, 1, "R10 bit 12 set");
    drive(1, enc(5'h0A, 0, 6'h0C), 8'h00, 8'h41, 2'd1, 1, 0, 1, "R2 R11 inc acc dest");
    drive(0, '0, 8'h00, 8'h00, 2'd0, 0, 0, 0, "R1 trailing idle");
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule